// File: doc/BRIEF.md
# Per-Port Playout Underrun Guard

This block watches the circular buffers of a multi-port reassembly engine. Each port has a playout reader and a reassembly writer. Every cycle the block compares the two pointers of each port. When the reader has caught up with the writer, the reader is about to fetch a location that nothing has written yet. The block marks that port as dry and raises two one-cycle notices. One notice goes to the writer, so that it can choose a new write address. The other goes to the statistics side, and a per-port event counter counts the entry.

While a port is dry, every read on that port returns idle data (all ones) in place of the buffer contents. The writer ends the condition by pulsing a resync strobe while presenting a write pointer that no longer equals the read pointer. The next read on that port returns buffer data again. Each port is tracked separately. The policy the writer uses to pick its new pointer lies outside this block.

Top module: `cbuf_underrun_guard`

## Requirements
- R1: A port whose read pointer equals its write pointer, and which is not already dry, shows its dry flag from the next clock edge. Port p's pointers sit at bits [p*PTR_W +: PTR_W] of the packed pointer inputs.
- R2: The writer notice for a port is a one-cycle pulse, issued in the same cycle the dry flag first shows. It is not repeated while the port stays dry.
- R3: The statistics notice for a port follows the same timing as the writer notice, and is issued only on entry into the dry state.
- R4: Each entry into the dry state adds one to that port's CNT_W-bit event counter. The counter holds at all ones once it reaches that value. Port p's count sits at bits [p*CNT_W +: CNT_W] of the packed count output.
- R5: A read strobe aimed at a port that is dry, or that meets the equality condition in that same cycle, produces all-ones output data.
- R6: A dry port returns to normal at the edge where its resync bit is high and its write pointer differs from its read pointer. A resync while the pointers are still equal leaves the port dry. The first read after the clear returns buffer data.
- R7: Detection, notices, counting and clearing on one port do not change the flag, notices or count of any other port.
- R8: After reset, all flags, notices, counts, the output data and the output valid bit are zero.
- R9: A read strobe with a port number and input data produces the selected data on the output one clock edge later, with the valid bit high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_ptr_vec | input | NUM_PORTS*PTR_W | Packed playout read pointers |
| wr_ptr_vec | input | NUM_PORTS*PTR_W | Packed reassembly write pointers |
| resync | input | NUM_PORTS | Per-port strobe from the writer: new pointer valid |
| rd_stb | input | 1 | Playout read strobe |
| rd_port | input | PORT_W | Port being read |
| rd_data | input | DATA_W | Data fetched from the buffer |
| out_data | output | DATA_W | Data to the serial side, all ones when dry |
| out_valid | output | 1 | out_data is valid |
| dry | output | NUM_PORTS | Per-port underrun flag |
| wr_note | output | NUM_PORTS | One-cycle notice to the writer |
| st_note | output | NUM_PORTS | One-cycle notice to statistics |
| ev_count | output | NUM_PORTS*CNT_W | Packed saturating underrun counts |

## Verification
If a port's internal dry state is wrong, it shows at the ports one edge after the equality appears, or one edge after a resync. The dry flag, the notices and the next read's output data all show it, so a sweep over every pointer pair on every port exposes a bad comparison within one cycle. A lost or duplicated entry shows as a count that differs from the arithmetic expectation, and a saturation fault shows as a counter that wraps. Because the idle ports are checked on every step, any crosstalk between ports is caught on the cycle it happens.

// File: rtl/cuf_pkg.sv
package cuf_pkg;
   typedef enum logic {
      ST_FLOW = 1'b0,
      ST_DRY  = 1'b1
   } flow_st_e;

   function automatic logic [31:0] sat_max(input int w);
      return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
   endfunction
endpackage

// File: rtl/cuf_sat_cnt.sv
module cuf_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = '1;

   generate
      if (W < 1) begin : g_bad
         $error("cuf_sat_cnt: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (inc && cnt != TOP)   cnt <= cnt + 1'b1;
   end

   assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == TOP) |=> (cnt == TOP));
   assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc) |=> $stable(cnt));
endmodule

// File: rtl/cuf_port_trk.sv
module cuf_port_trk
   import cuf_pkg::*;
#(
   parameter int PTR_W    = 10,
   parameter int CNT_W    = 16,
   parameter bit COUNT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PTR_W-1:0] rd_ptr,
   input  logic [PTR_W-1:0] wr_ptr,
   input  logic             resync,
   output logic             dry,
   output logic             enter_now,
   output logic             wr_note,
   output logic             st_note,
   output logic [CNT_W-1:0] ev_cnt
);
   flow_st_e st_q, st_d;
   logic     caught;
   logic     leave;

   assign caught    = (rd_ptr == wr_ptr);
   assign enter_now = (st_q == ST_FLOW) && caught;
   assign leave     = (st_q == ST_DRY) && resync && !caught;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_FLOW: if (caught) st_d = ST_DRY;
         ST_DRY:  if (leave)  st_d = ST_FLOW;
         default: st_d = ST_FLOW;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_FLOW;
         wr_note <= 1'b0;
         st_note <= 1'b0;
      end else begin
         st_q    <= st_d;
         wr_note <= enter_now;
         st_note <= enter_now;
      end
   end

   assign dry = (st_q == ST_DRY);

   generate
      if (COUNT_EN) begin : g_cnt
         cuf_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (enter_now),
            .cnt   (ev_cnt)
         );
      end else begin : g_nocnt
         assign ev_cnt = '0;
      end
   endgenerate

   assert_detect_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!dry && rd_ptr == wr_ptr) |=> dry);
   assert_note_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_note |-> (dry && !$past(dry)));
   assert_stat_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dry) |-> st_note);
   assert_clear_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dry) |-> $past(resync && rd_ptr != wr_ptr));
endmodule

// File: rtl/cuf_fill_mux.sv
module cuf_fill_mux #(
   parameter int NUM_PORTS = 8,
   parameter int DATA_W    = 8,
   parameter int PORT_W    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_stb,
   input  logic [PORT_W-1:0]    rd_port,
   input  logic [DATA_W-1:0]    rd_data,
   input  logic [NUM_PORTS-1:0] fill_vec,
   output logic [DATA_W-1:0]    out_data,
   output logic                 out_valid
);
   localparam logic [DATA_W-1:0] IDLE = '1;
   logic fill_sel;

   always_comb begin
      fill_sel = 1'b0;
      for (int i = 0; i < NUM_PORTS; i++) begin
         if (int'(rd_port) == i) fill_sel = fill_vec[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= rd_stb;
         if (rd_stb) out_data <= fill_sel ? IDLE : rd_data;
      end
   end

   assert_idle_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && fill_sel) |=> (out_data == IDLE));
   assert_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> out_valid);
endmodule

// File: rtl/cbuf_underrun_guard.sv
module cbuf_underrun_guard #(
   parameter int  NUM_PORTS = 8,
   parameter int  PTR_W     = 10,
   parameter int  DATA_W    = 8,
   parameter int  CNT_W     = 16,
   parameter bit  COUNT_EN  = 1'b1,
   localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PORTS*PTR_W-1:0] rd_ptr_vec,
   input  logic [NUM_PORTS*PTR_W-1:0] wr_ptr_vec,
   input  logic [NUM_PORTS-1:0]       resync,
   input  logic                       rd_stb,
   input  logic [PORT_W-1:0]          rd_port,
   input  logic [DATA_W-1:0]          rd_data,
   output logic [DATA_W-1:0]          out_data,
   output logic                       out_valid,
   output logic [NUM_PORTS-1:0]       dry,
   output logic [NUM_PORTS-1:0]       wr_note,
   output logic [NUM_PORTS-1:0]       st_note,
   output logic [NUM_PORTS*CNT_W-1:0] ev_count
);
   logic [NUM_PORTS-1:0] enter_now;
   logic [NUM_PORTS-1:0] fill_vec;

   generate
      if (NUM_PORTS < 1)  begin : g_np_bad  $error("NUM_PORTS must be >= 1"); end
      if (PTR_W < 1)      begin : g_pw_bad  $error("PTR_W must be >= 1");     end
      if (DATA_W < 1)     begin : g_dw_bad  $error("DATA_W must be >= 1");    end
      if (CNT_W < 1)      begin : g_cw_bad  $error("CNT_W must be >= 1");     end

      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         cuf_port_trk #(
            .PTR_W    (PTR_W),
            .CNT_W    (CNT_W),
            .COUNT_EN (COUNT_EN)
         ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_ptr    (rd_ptr_vec[p*PTR_W +: PTR_W]),
            .wr_ptr    (wr_ptr_vec[p*PTR_W +: PTR_W]),
            .resync    (resync[p]),
            .dry       (dry[p]),
            .enter_now (enter_now[p]),
            .wr_note   (wr_note[p]),
            .st_note   (st_note[p]),
            .ev_cnt    (ev_count[p*CNT_W +: CNT_W])
         );
      end
   endgenerate

   assign fill_vec = dry | enter_now;

   cuf_fill_mux #(
      .NUM_PORTS (NUM_PORTS),
      .DATA_W    (DATA_W),
      .PORT_W    (PORT_W)
   ) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_stb    (rd_stb),
      .rd_port   (rd_port),
      .rd_data   (rd_data),
      .fill_vec  (fill_vec),
      .out_data  (out_data),
      .out_valid (out_valid)
   );

   assert_notes_paired_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_note == st_note);
   assert_note_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_note & ~dry) == '0);
endmodule

// File: tb/sim_cbuf_underrun_guard.sv
module sim_cbuf_underrun_guard;
   localparam int CLK_PER = 10;
   localparam int NP = 8;
   localparam int PW = 4;
   localparam int DW = 8;
   localparam int CW = 4;
   localparam int PRW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP*PW-1:0] rdv, wrv;
   logic [NP-1:0] rsy;
   logic rd_stb;
   logic [PRW-1:0] rd_port;
   logic [DW-1:0] rd_data;
   logic [DW-1:0] out_data;
   logic out_valid;
   logic [NP-1:0] dry, wr_note, st_note;
   logic [NP*CW-1:0] ev_count;

   int n_chk = 0;
   int n_bad = 0;
   int exp_cnt [NP];
   bit done = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   cbuf_underrun_guard #(.NUM_PORTS(NP), .PTR_W(PW), .DATA_W(DW), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .rd_ptr_vec(rdv), .wr_ptr_vec(wrv), .resync(rsy),
      .rd_stb(rd_stb), .rd_port(rd_port), .rd_data(rd_data), .out_data(out_data),
      .out_valid(out_valid), .dry(dry), .wr_note(wr_note), .st_note(st_note),
      .ev_count(ev_count));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle_ptrs();
      for (int q = 0; q < NP; q++) begin
         rdv[q*PW +: PW] = '0;
         wrv[q*PW +: PW] = 4'd1;
      end
   endtask

   task automatic chk_counts(input string tag);
      for (int q = 0; q < NP; q++)
         chk(tag, 64'(ev_count[q*CW +: CW]), 64'(exp_cnt[q]));
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
   end

   initial begin
      idle_ptrs();
      rsy = '0; rd_stb = 1'b0; rd_port = '0; rd_data = '0;
      for (int q = 0; q < NP; q++) exp_cnt[q] = 0;
      #3;
      // R8 reset state
      chk("R8 dry", 64'(dry), 64'h0);
      chk("R8 wr_note", 64'(wr_note), 64'h0);
      chk("R8 st_note", 64'(st_note), 64'h0);
      chk("R8 count", 64'(ev_count), 64'h0);
      chk("R8 out_data", 64'(out_data), 64'h0);
      chk("R8 out_valid", 64'(out_valid), 64'h0);
      tick(); tick();
      rst_n = 1'b1;
      tick();

      // R9 plain read
      rd_stb = 1'b1; rd_port = 3'd2; rd_data = 8'h5A;
      tick();
      rd_stb = 1'b0;
      chk("R9 data", 64'(out_data), 64'h5A);
      chk("R9 valid", 64'(out_valid), 64'h1);
      tick();
      chk("R9 valid drop", 64'(out_valid), 64'h0);

      // R1 R2 R3 R4 R6 R7 sweep over every pointer pair on every port
      for (int p = 0; p < NP; p++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               logic [NP-1:0] m;
               m = '0; m[p] = (a == b);
               idle_ptrs();
               rdv[p*PW +: PW] = 4'(a);
               wrv[p*PW +: PW] = 4'(b);
               tick();
               if (a == b && exp_cnt[p] < 15) exp_cnt[p]++;
               chk("R1 R7 dry", 64'(dry), 64'(m));
               chk("R2 wr_note", 64'(wr_note), 64'(m));
               chk("R3 st_note", 64'(st_note), 64'(m));
               chk("R4 R7 count", 64'(ev_count[p*CW +: CW]), 64'(exp_cnt[p]));
               if (a == b) begin
                  tick();
                  chk("R2 no repeat", 64'(wr_note), 64'h0);
                  chk("R3 no repeat", 64'(st_note), 64'h0);
                  chk("R1 hold", 64'(dry), 64'(m));
                  wrv[p*PW +: PW] = 4'(a + 1);
                  rsy[p] = 1'b1;
                  tick();
                  rsy = '0;
                  chk("R6 clear", 64'(dry), 64'h0);
               end
            end
         end
         chk_counts("R4 R7 all counts");
      end
      // R4 saturation: every port saw 16 entries with a 4-bit counter
      for (int q = 0; q < NP; q++) chk("R4 saturate", 64'(ev_count[q*CW +: CW]), 64'hF);

      // R5 R6 silence and resume on port 3
      idle_ptrs();
      rdv[3*PW +: PW] = 4'd7; wrv[3*PW +: PW] = 4'd7;
      rd_stb = 1'b1; rd_port = 3'd3; rd_data = 8'h3C;
      tick();
      chk("R5 same-cycle fill", 64'(out_data), 64'hFF);
      rd_port = 3'd2; rd_data = 8'h11;
      tick();
      chk("R5 R7 other port data", 64'(out_data), 64'h11);
      rd_port = 3'd3; rd_data = 8'h22;
      rsy[3] = 1'b1;
      tick();
      rsy = '0;
      chk("R6 resync equal keeps dry", 64'(dry), 64'h08);
      chk("R5 fill while dry", 64'(out_data), 64'hFF);
      wrv[3*PW +: PW] = 4'd9; rsy[3] = 1'b1; rd_data = 8'h44;
      tick();
      rsy = '0;
      chk("R6 cleared", 64'(dry), 64'h0);
      chk("R6 read during clear is idle", 64'(out_data), 64'hFF);
      rd_data = 8'h66;
      tick();
      rd_stb = 1'b0;
      chk("R6 resume data", 64'(out_data), 64'h66);
      chk_counts("R4 final counts");
      tick();
      finish_up();
   end
endmodule